// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block runs page programming commands against a small flash array that is modelled in registers. Each group of pages (a region) has its own lock bit. Software writes a single command word that carries a key, a page number and an opcode. When the word is accepted, the sequencer drops the ready flag. It then optionally erases the target page and merges the page image, one word per cycle, from an external staging buffer. Flash cells can only change from 1 to 0, so each stored word becomes the old word ANDed with the staged word. The command can also lock the region that holds the page. At the end, the sequencer pulses a request for the staging buffer to refill itself with ones, and then raises the ready flag again.

Reads of the array use a valid/ready handshake. `rd_ready_o` follows the ready flag, so a request is held back for as long as an operation runs. The requester keeps `rd_valid_i` and `rd_addr_i` steady until `rd_ready_o` is high. A request is accepted in a cycle where both signals are high. The data appears on `rdata_o` one cycle later, with `rdata_valid_o` high for that single cycle, and there is no back-pressure on the response.

A command that is refused never starts, and it records why in one of two sticky error flags. A status-read strobe clears both flags. If the ready-interrupt enable is set, an interrupt pulse marks the rise of the ready flag.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, `ready_o` is 1, both error flags, `irq_o` and every lock bit are 0, and every array word reads all ones.
- R2: The command word holds the key in bits 31:24 (must equal 0x5A), the page number in bits 23:8 and the opcode in bits 7:0. The opcodes are: 0x01 program, 0x02 program then lock, 0x03 erase then program, 0x04 erase then program then lock.
- R3: Programming touches only the addressed page. Each of its words becomes old word AND buffer word, where `buf_addr_o` selects the buffer word for word index 0 to WORDS_PER_PAGE-1.
- R4: The erase-first opcodes set every word of the page to all ones before merging, so the page ends equal to the buffer image.
- R5: `ready_o` reads 0 in the cycle after an accepted command write. It reads 1 again WORDS_PER_PAGE+1 cycles after the write for the program-only opcodes, and ERASE_CYCLES+WORDS_PER_PAGE+1 cycles after the write for the erase-first opcodes.
- R6: `irq_o` is a one-cycle pulse in the cycle where `ready_o` rises. It occurs only if `irq_en` was high in the cycle before.
- R7: While `ready_o` is 0, `rd_ready_o` is 0 and no read is accepted. An accepted read returns the addressed word one cycle later.
- R8: The locking opcodes set lock bit page/PAGES_PER_REGION of `lock_o` when `ready_o` rises. Lock bits stay set until reset.
- R9: A well-formed command aimed at a page in a locked region sets `lock_err_o`, leaves `ready_o` high and changes no data.
- R10: `buf_reinit_o` pulses for exactly one cycle per executed command, in the cycle just before `ready_o` rises. It does not pulse for rejected commands.
- R11: A wrong key, an unknown opcode or a page number of NUM_PAGES or more sets `cmd_err_o` and starts nothing.
- R12: A command written while `ready_o` is 0 is ignored and sets `cmd_err_o`.
- R13: A `stat_rd` strobe clears both error flags at the next edge. If a new error is raised in the same cycle, that error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: key, page, opcode |
| irq_en | input | 1 | Ready-interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears error flags |
| ready_o | output | 1 | Ready flag |
| cmd_err_o | output | 1 | Command error flag |
| lock_err_o | output | 1 | Lock error flag |
| irq_o | output | 1 | Ready interrupt pulse |
| lock_o | output | NUM_PAGES/PAGES_PER_REGION | Region lock bits |
| buf_addr_o | output | log2(WORDS_PER_PAGE) | Staging buffer word index |
| buf_data_i | input | DATA_W | Staging buffer word |
| buf_reinit_o | output | 1 | Request to refill the staging buffer with ones |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request accepted when high |
| rd_addr_i | input | log2(NUM_PAGES*WORDS_PER_PAGE) | Read word address {page, word} |
| rdata_valid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |

## Verification
The hardest case to reach is a second command that lands while the first is still running. The stimulus reaches it by starting an erase-first command and writing a program command to a neighbouring page during the erase window. The bench then confirms that the neighbour still reads erased and that the first page holds its image. The other difficult case is the lock rejection: the bench first locks a region through a locking opcode, then aims a command at a different page in the same region and reads that page back unchanged.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ERASE  = 2'd1,
    SQ_MERGE  = 2'd2,
    SQ_FINISH = 2'd3
  } seq_state_t;

  localparam logic [7:0] OPC_PROG      = 8'h01;
  localparam logic [7:0] OPC_PROG_LOCK = 8'h02;
  localparam logic [7:0] OPC_ERPR      = 8'h03;
  localparam logic [7:0] OPC_ERPR_LOCK = 8'h04;

  typedef struct packed {
    logic known;
    logic erase;
    logic lock;
  } op_attr_t;

  function automatic op_attr_t op_attr(input logic [7:0] opc);
    op_attr_t a;
    a = '0;
    case (opc)
      OPC_PROG:      a = '{known: 1'b1, erase: 1'b0, lock: 1'b0};
      OPC_PROG_LOCK: a = '{known: 1'b1, erase: 1'b0, lock: 1'b1};
      OPC_ERPR:      a = '{known: 1'b1, erase: 1'b1, lock: 1'b0};
      OPC_ERPR_LOCK: a = '{known: 1'b1, erase: 1'b1, lock: 1'b1};
      default:       a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/fpp_cmd_decode.sv
module fpp_cmd_decode
  import fpp_pkg::*;
#(
  parameter int         NUM_PAGES = 16,
  parameter logic [7:0] CMD_KEY   = 8'h5A,
  localparam int        PW        = $clog2(NUM_PAGES)
) (
  input  logic [31:0]   cmd_word,
  output logic          well_formed,
  output logic          want_erase,
  output logic          want_lock,
  output logic [PW-1:0] page
);

  logic [15:0] page_field;
  op_attr_t    attr;

  always_comb begin
    page_field  = cmd_word[23:8];
    attr        = op_attr(cmd_word[7:0]);
    page        = page_field[PW-1:0];
    want_erase  = attr.erase;
    want_lock   = attr.lock;
    well_formed = (cmd_word[31:24] == CMD_KEY) && attr.known &&
                  (page_field < 16'(NUM_PAGES));
  end

endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
  import fpp_pkg::*;
#(
  parameter int  NUM_PAGES      = 16,
  parameter int  WORDS_PER_PAGE = 8,
  parameter int  ERASE_CYCLES   = 12,
  localparam int PW             = $clog2(NUM_PAGES),
  localparam int WW             = $clog2(WORDS_PER_PAGE),
  localparam int CNT_MAX        = (ERASE_CYCLES > WORDS_PER_PAGE) ? ERASE_CYCLES : WORDS_PER_PAGE,
  localparam int CW             = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_erase,
  input  logic          start_lock,
  input  logic [PW-1:0] start_page,
  output logic          erase_en,
  output logic          merge_en,
  output logic [WW-1:0] word_idx,
  output logic [PW-1:0] act_page,
  output logic          lock_set,
  output logic          done
);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      lock_q   <= 1'b0;
      act_page <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            act_page <= start_page;
            lock_q   <= start_lock;
            cnt      <= '0;
            state    <= start_erase ? SQ_ERASE : SQ_MERGE;
          end
        end
        SQ_ERASE: begin
          if (cnt == CW'(ERASE_CYCLES - 1)) begin
            cnt   <= '0;
            state <= SQ_MERGE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_MERGE: begin
          if (cnt == CW'(WORDS_PER_PAGE - 1)) begin
            cnt   <= '0;
            state <= SQ_FINISH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          lock_q <= 1'b0;
          state  <= SQ_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    erase_en = (state == SQ_ERASE) && (cnt == CW'(ERASE_CYCLES - 1));
    merge_en = (state == SQ_MERGE);
    word_idx = cnt[WW-1:0];
    done     = (state == SQ_FINISH);
    lock_set = done && lock_q;
  end

endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
  parameter int  DATA_W           = 32,
  parameter int  NUM_PAGES        = 16,
  parameter int  WORDS_PER_PAGE   = 8,
  parameter int  PAGES_PER_REGION = 4,
  localparam int PW               = $clog2(NUM_PAGES),
  localparam int WW               = $clog2(WORDS_PER_PAGE),
  localparam int AW               = PW + WW,
  localparam int NW               = 1 << AW,
  localparam int NR               = NUM_PAGES / PAGES_PER_REGION,
  localparam int RS               = $clog2(PAGES_PER_REGION),
  localparam int RW               = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_en,
  input  logic              merge_en,
  input  logic [PW-1:0]     act_page,
  input  logic [WW-1:0]     word_idx,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              lock_set,
  input  logic              rd_accept,
  input  logic [AW-1:0]     rd_addr,
  output logic              rdata_valid,
  output logic [DATA_W-1:0] rdata,
  output logic [NR-1:0]     locks
);

  logic [DATA_W-1:0] mem [NW];
  logic [RW-1:0]     act_region;
  logic [AW-1:0]     merge_addr;

  always_comb begin
    act_region = RW'(act_page >> RS);
    merge_addr = {act_page, word_idx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else if (erase_en) begin
      for (int w = 0; w < WORDS_PER_PAGE; w++) mem[{act_page, WW'(w)}] <= '1;
    end else if (merge_en) begin
      mem[merge_addr] <= mem[merge_addr] & buf_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locks <= '0;
    end else if (lock_set) begin
      locks[act_region] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else begin
      rdata_valid <= rd_accept;
      if (rd_accept) rdata <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/fpp_status.sv
module fpp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  input  logic set_cmd_err,
  input  logic set_lock_err,
  input  logic stat_rd,
  input  logic irq_en,
  output logic ready,
  output logic cmd_err,
  output logic lock_err,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready    <= 1'b1;
      cmd_err  <= 1'b0;
      lock_err <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (start)     ready <= 1'b0;
      else if (done) ready <= 1'b1;
      irq <= done && irq_en;
      if (set_cmd_err)  cmd_err <= 1'b1;
      else if (stat_rd) cmd_err <= 1'b0;
      if (set_lock_err) lock_err <= 1'b1;
      else if (stat_rd) lock_err <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int         DATA_W           = 32,
  parameter int         NUM_PAGES        = 16,
  parameter int         WORDS_PER_PAGE   = 8,
  parameter int         PAGES_PER_REGION = 4,
  parameter int         ERASE_CYCLES     = 12,
  parameter logic [7:0] CMD_KEY          = 8'h5A,
  localparam int        PW               = $clog2(NUM_PAGES),
  localparam int        WW               = $clog2(WORDS_PER_PAGE),
  localparam int        AW               = PW + WW,
  localparam int        NR               = NUM_PAGES / PAGES_PER_REGION,
  localparam int        RS               = $clog2(PAGES_PER_REGION),
  localparam int        RW               = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  input  logic              irq_en,
  input  logic              stat_rd,
  output logic              ready_o,
  output logic              cmd_err_o,
  output logic              lock_err_o,
  output logic              irq_o,
  output logic [NR-1:0]     lock_o,
  output logic [WW-1:0]     buf_addr_o,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              buf_reinit_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rdata_valid_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic          well_formed, want_erase, want_lock;
  logic [PW-1:0] cmd_page;
  logic [PW-1:0] act_page;
  logic          erase_en, merge_en, lock_set, done;
  logic          start, set_cmd_err, set_lock_err;
  logic [RW-1:0] cmd_region;

  fpp_cmd_decode #(.NUM_PAGES(NUM_PAGES), .CMD_KEY(CMD_KEY)) dec_i (
    .cmd_word    (cmd_wdata),
    .well_formed (well_formed),
    .want_erase  (want_erase),
    .want_lock   (want_lock),
    .page        (cmd_page)
  );

  always_comb begin
    cmd_region   = RW'(cmd_page >> RS);
    start        = 1'b0;
    set_cmd_err  = 1'b0;
    set_lock_err = 1'b0;
    if (cmd_we) begin
      if (!ready_o || !well_formed) set_cmd_err  = 1'b1;
      else if (lock_o[cmd_region])  set_lock_err = 1'b1;
      else                          start        = 1'b1;
    end
  end

  fpp_seq #(
    .NUM_PAGES(NUM_PAGES), .WORDS_PER_PAGE(WORDS_PER_PAGE), .ERASE_CYCLES(ERASE_CYCLES)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_erase (want_erase),
    .start_lock  (want_lock),
    .start_page  (cmd_page),
    .erase_en    (erase_en),
    .merge_en    (merge_en),
    .word_idx    (buf_addr_o),
    .act_page    (act_page),
    .lock_set    (lock_set),
    .done        (done)
  );

  fpp_array #(
    .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .WORDS_PER_PAGE(WORDS_PER_PAGE),
    .PAGES_PER_REGION(PAGES_PER_REGION)
  ) arr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase_en    (erase_en),
    .merge_en    (merge_en),
    .act_page    (act_page),
    .word_idx    (buf_addr_o),
    .buf_data    (buf_data_i),
    .lock_set    (lock_set),
    .rd_accept   (rd_valid_i && rd_ready_o),
    .rd_addr     (rd_addr_i),
    .rdata_valid (rdata_valid_o),
    .rdata       (rdata_o),
    .locks       (lock_o)
  );

  fpp_status st_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (done),
    .set_cmd_err  (set_cmd_err),
    .set_lock_err (set_lock_err),
    .stat_rd      (stat_rd),
    .irq_en       (irq_en),
    .ready        (ready_o),
    .cmd_err      (cmd_err_o),
    .lock_err     (lock_err_o),
    .irq          (irq_o)
  );

  assign rd_ready_o   = ready_o;
  assign buf_reinit_o = done;

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
  parameter int         NUM_PAGES        = 16,
  parameter int         PAGES_PER_REGION = 4,
  parameter logic [7:0] CMD_KEY          = 8'h5A,
  localparam int        PW               = $clog2(NUM_PAGES),
  localparam int        NR               = NUM_PAGES / PAGES_PER_REGION,
  localparam int        RS               = $clog2(PAGES_PER_REGION),
  localparam int        RW               = (NR > 1) ? $clog2(NR) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [31:0]   cmd_wdata,
  input logic          irq_en,
  input logic          ready_o,
  input logic          cmd_err_o,
  input logic          lock_err_o,
  input logic          irq_o,
  input logic [NR-1:0] lock_o,
  input logic          buf_reinit_o,
  input logic          rdata_valid_o
);

  logic [15:0]   pf;
  logic          good_cmd;
  logic          tgt_locked;

  always_comb begin
    pf         = cmd_wdata[23:8];
    good_cmd   = (cmd_wdata[31:24] == CMD_KEY) && (cmd_wdata[7:0] >= 8'h01) &&
                 (cmd_wdata[7:0] <= 8'h04) && (pf < 16'(NUM_PAGES));
    tgt_locked = lock_o[RW'(pf[PW-1:0] >> RS)];
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && ready_o && good_cmd && !tgt_locked) |=> !ready_o); // R5

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $rose(ready_o)); // R6

  AST_IRQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_o) && $past(irq_en)) |-> irq_o); // R6

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> !rdata_valid_o); // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_o) & ~lock_o) == '0)); // R8

  AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && ready_o && good_cmd && tgt_locked) |=> (lock_err_o && ready_o)); // R9

  AST_REINIT_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_reinit_o |=> $rose(ready_o)); // R10

  AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !ready_o) |=> cmd_err_o); // R12

endmodule

bind flash_page_prog fpp_checker #(
  .NUM_PAGES(NUM_PAGES), .PAGES_PER_REGION(PAGES_PER_REGION), .CMD_KEY(CMD_KEY)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_we        (cmd_we),
  .cmd_wdata     (cmd_wdata),
  .irq_en        (irq_en),
  .ready_o       (ready_o),
  .cmd_err_o     (cmd_err_o),
  .lock_err_o    (lock_err_o),
  .irq_o         (irq_o),
  .lock_o        (lock_o),
  .buf_reinit_o  (buf_reinit_o),
  .rdata_valid_o (rdata_valid_o)
);

// File: tb/flash_page_prog_tb_top.sv
module flash_page_prog_tb_top;
  localparam int DW = 32, NP = 16, WPP = 8, PPR = 4, EC = 12;
  localparam int WW = 3, PW = 4, AW = 7, NR = 4;
  localparam logic [7:0] KEY = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, irq_en = 1'b0, stat_rd = 1'b0, rd_valid = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic ready, cmd_err, lock_err, irq, buf_reinit, rd_ready, rdata_valid;
  logic [NR-1:0] lock_o;
  logic [WW-1:0] buf_addr;
  logic [DW-1:0] buf_data, rdata;

  logic [DW-1:0] bufmem [WPP];
  logic [DW-1:0] exp_mem [1 << AW];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  int n_chk = 0, n_fail = 0, irq_cnt = 0, reinit_cnt = 0, cyc = 0;
  bit fin = 1'b0;

  always #2.5ns clk = ~clk;

  assign buf_data = bufmem[buf_addr];

  flash_page_prog dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .irq_en(irq_en), .stat_rd(stat_rd), .ready_o(ready), .cmd_err_o(cmd_err),
    .lock_err_o(lock_err), .irq_o(irq), .lock_o(lock_o), .buf_addr_o(buf_addr),
    .buf_data_i(buf_data), .buf_reinit_o(buf_reinit), .rd_valid_i(rd_valid),
    .rd_ready_o(rd_ready), .rd_addr_i(rd_addr), .rdata_valid_o(rdata_valid),
    .rdata_o(rdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // staging buffer model: refills with ones on request
  always @(posedge clk)
    if (buf_reinit) for (int w = 0; w < WPP; w++) bufmem[w] <= '1;

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (buf_reinit) reinit_cnt++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rdata_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected read data actual=%h expected=none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic fill_buf(input logic [31:0] seed);
    for (int w = 0; w < WPP; w++) bufmem[w] = seed ^ (32'h0F0F_0001 << w);
  endtask

  task automatic model(input logic [7:0] op, input int page);
    for (int w = 0; w < WPP; w++) begin
      if (op >= 8'h03) exp_mem[page*WPP + w] = '1;
      exp_mem[page*WPP + w] = exp_mem[page*WPP + w] & bufmem[w];
    end
  endtask

  task automatic send(input logic [7:0] key, input logic [15:0] page, input logic [7:0] op);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = {key, page, op};
    @(posedge clk); #1ns;
    cmd_we = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
  endtask

  task automatic read_word(input int addr, input string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = AW'(addr);
    exp_q.push_back(exp_mem[addr]); tag_q.push_back(req);
    @(posedge clk); #1ns;
    rd_valid = 1'b0;
  endtask

  task automatic read_page(input int page, input string req);
    for (int w = 0; w < WPP; w++) read_word(page*WPP + w, req);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] op, input int page, input bit ien, input string req);
    int n, i0, r0, busy;
    irq_en = ien;
    model(op, page);
    i0 = irq_cnt; r0 = reinit_cnt;
    busy = (op >= 8'h03) ? EC + WPP + 1 : WPP + 1;
    send(KEY, 16'(page), op);
    chk({31'b0, ready}, 32'd0, "R5 ready low after command");
    wait_ready(n);
    chk(n, busy, "R5 busy length");
    @(negedge clk);
    chk(irq_cnt - i0, ien ? 1 : 0, "R6 irq pulses");
    chk(reinit_cnt - r0, 1, "R10 reinit pulses");
    read_page(page, req);
  endtask

  task automatic strobe_status();
    @(negedge clk); stat_rd = 1'b1;
    @(posedge clk); #1ns; stat_rd = 1'b0;
  endtask

  initial begin
    int n, r0;
    for (int w = 0; w < WPP; w++) bufmem[w] = '1;
    for (int i = 0; i < (1 << AW); i++) exp_mem[i] = '1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk({28'b0, ready, cmd_err, lock_err, irq}, 32'h8, "R1 flags after reset");
    chk({28'b0, lock_o}, 32'h0, "R1 locks after reset");
    read_word(3, "R1 erased word");
    read_word(127, "R1 erased word");

    // R2 R3 program-only, merge twice
    fill_buf(32'hFFFF_00FF);
    run_cmd(8'h01, 2, 1'b1, "R3 program page 2");
    fill_buf(32'h0FF0_FFFF);
    run_cmd(8'h01, 2, 1'b0, "R3 AND accumulate page 2");
    read_page(3, "R3 neighbour page untouched");

    // R4 erase first
    fill_buf(32'hA5A5_5A5A);
    run_cmd(8'h03, 2, 1'b1, "R4 erase then program page 2");

    // R8 program and lock region 1
    fill_buf(32'h1234_5678);
    run_cmd(8'h02, 5, 1'b0, "R8 program lock page 5");
    chk({28'b0, lock_o}, 32'h2, "R8 region 1 locked");

    // R9 locked target
    r0 = reinit_cnt;
    fill_buf(32'h0);
    send(KEY, 16'd6, 8'h03);
    @(negedge clk);
    chk({30'b0, lock_err, ready}, 32'h3, "R9 lock_err set, ready high");
    chk(reinit_cnt - r0, 0, "R10 no reinit on reject");
    read_page(6, "R9 locked page unchanged");

    // R13 clear on status read
    strobe_status();
    @(negedge clk);
    chk({31'b0, lock_err}, 32'h0, "R13 lock_err cleared");

    // R11 malformed commands
    send(8'hA5, 16'd1, 8'h01);
    @(negedge clk);
    chk({30'b0, cmd_err, ready}, 32'h3, "R11 bad key");
    strobe_status();
    send(KEY, 16'd1, 8'h07);
    @(negedge clk);
    chk({30'b0, cmd_err, ready}, 32'h3, "R11 unknown opcode");
    strobe_status();
    send(KEY, 16'd16, 8'h01);
    @(negedge clk);
    chk({30'b0, cmd_err, ready}, 32'h3, "R11 page out of range");
    strobe_status();
    @(negedge clk);
    chk({31'b0, cmd_err}, 32'h0, "R13 cmd_err cleared");
    read_page(1, "R11 page 1 untouched");

    // R13 set wins over clear
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = {8'h00, 16'd1, 8'h01}; stat_rd = 1'b1;
    @(posedge clk); #1ns; cmd_we = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
    chk({31'b0, cmd_err}, 32'h1, "R13 set wins");
    strobe_status();

    // R12 R7 command and read while busy
    fill_buf(32'h00FF_FF00);
    model(8'h03, 10);
    send(KEY, 16'd10, 8'h03);
    @(negedge clk);
    chk({31'b0, rd_ready}, 32'h0, "R7 rd_ready low while busy");
    rd_valid = 1'b1; rd_addr = AW'(10*WPP);
    @(posedge clk); #1ns; rd_valid = 1'b0;
    send(KEY, 16'd11, 8'h01);
    wait_ready(n);
    @(negedge clk);
    chk({31'b0, cmd_err}, 32'h1, "R12 busy command flagged");
    read_page(11, "R12 ignored command left page 11 erased");
    read_page(10, "R12 running command completed");
    strobe_status();

    // R8 erase-program-lock in region 2
    fill_buf(32'hCAFE_F00D);
    run_cmd(8'h04, 9, 1'b1, "R4 erase program lock page 9");
    chk({28'b0, lock_o}, 32'h6, "R8 region 2 locked, region 1 kept");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R7 all reads answered");
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule